// File: doc/BRIEF.md
# Two-Word Instruction Fetch and Operand Decode Stage

This stage sits at the front of a 32-bit load/store processor. It steps a byte-addressed, word-aligned program counter through instruction memory. It reads each instruction word over a request/valid port with a fixed one-cycle latency. For the three-operand format it reads the source operands out of a 32-entry register file, which it holds itself. The result goes to the execute stage as a decoded bundle under a valid/ready handshake.

Operand 2 comes from one of three places: a register, a small field inside the word, or a full 32-bit literal held in the word that follows. In the last case the stage issues a second memory read, and the instruction takes 8 bytes instead of 4. Memory-access instructions are flagged, and their 12-bit sub-operation code is passed along. Their effective address, operand 1 plus operand 2, is also computed here.

Words that are not in the three-operand format are passed through with an "other format" flag. They are always one word long. The register file is written through a simple write port driven by a later stage.

Top module: `fetch_decode`

## Requirements
- R1: While `rst` is high at a clock edge, `dec_valid` is low in the following cycle. In the first cycle after reset is released, a memory request is issued to address `RESET_VECTOR`.
- R2: `dec_three_op` is 1 exactly when bits [31:30] of the issued word are both 1, and `dec_other` is its complement.
- R3: For a three-operand word, `dec_dst` equals bits [4:0], and `dec_op1` equals the register selected by bits [14:10].
- R4: For a three-operand word with bit 15 clear, `dec_op2` equals the register selected by bits [9:5].
- R5: For a three-operand word with bit 15 set and bit 9 clear, `dec_op2` is bits [9:5] zero-extended to 32 bits.
- R6: For a three-operand word with bits 15 and 9 both set, `dec_op2` is the memory word at the next word address, and `dec_long` is 1. In every other case `dec_long` is 0.
- R7: Instructions are issued in address order, with `dec_pc` as the address of the instruction word. When an instruction is accepted, the next request goes to `dec_pc`+8 if `dec_long` is 1 and to `dec_pc`+4 otherwise. A word that is not three-operand never fetches a literal, whatever its bits 15 and 9 hold. Every request address is word aligned.
- R8: For a three-operand word, `dec_mem` equals bit 28. When `dec_mem` is 1, `dec_subop` equals bits [27:16] and `dec_ea` equals `dec_op1`+`dec_op2` modulo 2^32.
- R9: While `dec_valid` is high and `dec_ready` is low, the bundle holds steady. In the cycle after an accept, `dec_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_req | output | 1 | Read request to instruction memory |
| mem_addr | output | 32 | Byte address of the requested word |
| mem_rvalid | input | 1 | Read data valid, one cycle after a request |
| mem_rdata | input | 32 | Read data |
| rf_we | input | 1 | Register file write enable |
| rf_widx | input | 5 | Register file write index |
| rf_wdata | input | 32 | Register file write data |
| dec_valid | output | 1 | Decoded bundle valid |
| dec_ready | input | 1 | Execute stage accepts the bundle |
| dec_pc | output | 32 | Address of the instruction word |
| dec_instr | output | 32 | Raw instruction word |
| dec_three_op | output | 1 | Three-operand format |
| dec_other | output | 1 | Any other format |
| dec_long | output | 1 | Instruction carried a literal word |
| dec_mem | output | 1 | Memory-access instruction |
| dec_subop | output | 12 | Memory sub-operation code |
| dec_dst | output | 5 | Destination register index |
| dec_op1 | output | 32 | Operand 1 value |
| dec_op2 | output | 32 | Operand 2 value |
| dec_ea | output | 32 | Operand 1 plus operand 2 |

## Verification
Suppose the fetch machine takes the wrong branch on the literal flag. The damage shows at the port on the very next issued bundle. Either a literal word is decoded as an instruction, or an instruction word appears as `dec_op2`. After that, every later `dec_pc` is off by 4. The bench follows the expected address independently on every accept and checks each issued bundle field by field, so a single misstep is reported within one instruction. Wrong hold behaviour during a stall shows up as a changed field while `dec_ready` is low, and it is caught in that same cycle.

// File: rtl/fetch_decode.sv
module fetch_decode #(
  parameter logic [31:0] RESET_VECTOR = 32'h0000_0100
) (
  input  logic        clk,
  input  logic        rst,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata,
  input  logic        rf_we,
  input  logic [4:0]  rf_widx,
  input  logic [31:0] rf_wdata,
  output logic        dec_valid,
  input  logic        dec_ready,
  output logic [31:0] dec_pc,
  output logic [31:0] dec_instr,
  output logic        dec_three_op,
  output logic        dec_other,
  output logic        dec_long,
  output logic        dec_mem,
  output logic [11:0] dec_subop,
  output logic [4:0]  dec_dst,
  output logic [31:0] dec_op1,
  output logic [31:0] dec_op2,
  output logic [31:0] dec_ea
);
  localparam logic [31:0] WORD_STEP = 32'd4;

  typedef enum logic [1:0] {S_IDLE, S_INSTR, S_LIT, S_ISSUE} state_t;

  state_t      st;
  logic [31:0] pc, ipc, ir, lit;
  logic [31:0] rf [32];
  logic        want_lit;

  assign want_lit = (mem_rdata[31:30] == 2'b11) & mem_rdata[15] & mem_rdata[9];

  assign mem_req  = (st == S_IDLE)
                  | (st == S_INSTR && mem_rvalid && want_lit)
                  | (st == S_ISSUE && dec_ready);
  assign mem_addr = pc;

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= S_IDLE;
      pc  <= RESET_VECTOR;
      ipc <= RESET_VECTOR;
      ir  <= '0;
      lit <= '0;
    end else begin
      if (mem_req) pc <= pc + WORD_STEP;
      case (st)
        S_IDLE: begin
          ipc <= pc;
          st  <= S_INSTR;
        end
        S_INSTR: if (mem_rvalid) begin
          ir <= mem_rdata;
          st <= want_lit ? S_LIT : S_ISSUE;
        end
        S_LIT: if (mem_rvalid) begin
          lit <= mem_rdata;
          st  <= S_ISSUE;
        end
        default: if (dec_ready) begin
          ipc <= pc;
          st  <= S_INSTR;
        end
      endcase
    end
  end

  always_ff @(posedge clk)
    if (rf_we) rf[rf_widx] <= rf_wdata;

  assign dec_valid    = (st == S_ISSUE);
  assign dec_pc       = ipc;
  assign dec_instr    = ir;
  assign dec_three_op = (ir[31:30] == 2'b11);
  assign dec_other    = ~dec_three_op;
  assign dec_long     = dec_three_op & ir[15] & ir[9];
  assign dec_mem      = dec_three_op & ir[28];
  assign dec_subop    = ir[27:16];
  assign dec_dst      = ir[4:0];
  assign dec_op1      = rf[ir[14:10]];
  assign dec_op2      = !ir[15] ? rf[ir[9:5]] :
                        ir[9]   ? lit : {27'd0, ir[9:5]};
  assign dec_ea       = dec_op1 + dec_op2;

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !dec_valid);

  // R7
  aligned_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> mem_addr[1:0] == 2'b00);

  // R7
  next_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_ready) |-> (mem_req && mem_addr == dec_pc + (dec_long ? 32'd8 : 32'd4)));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && !dec_ready) |=> (dec_valid && $stable(dec_pc) && $stable(dec_instr)));

  // R9
  drop_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_ready) |=> !dec_valid);
endmodule

// File: tb/tb_fetch_decode.sv
module tb_fetch_decode;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RV = 32'h0000_0100;
  localparam int MW = 512;
  localparam int STOP_IDX = 490;

  logic clk, rst;
  logic mem_req, mem_rvalid;
  logic [31:0] mem_addr, mem_rdata;
  logic rf_we;
  logic [4:0] rf_widx;
  logic [31:0] rf_wdata;
  logic dec_valid, dec_ready;
  logic [31:0] dec_pc, dec_instr, dec_op1, dec_op2, dec_ea;
  logic dec_three_op, dec_other, dec_long, dec_mem;
  logic [11:0] dec_subop;
  logic [4:0] dec_dst;

  fetch_decode #(.RESET_VECTOR(RV)) dut (
    .clk(clk), .rst(rst), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .rf_we(rf_we), .rf_widx(rf_widx), .rf_wdata(rf_wdata),
    .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_pc(dec_pc),
    .dec_instr(dec_instr), .dec_three_op(dec_three_op), .dec_other(dec_other),
    .dec_long(dec_long), .dec_mem(dec_mem), .dec_subop(dec_subop),
    .dec_dst(dec_dst), .dec_op1(dec_op1), .dec_op2(dec_op2), .dec_ea(dec_ea)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] prog [MW];
  logic [31:0] regs [32];
  int nchk = 0;
  int nfail = 0;

  function automatic logic [31:0] rd(input logic [31:0] a);
    logic [31:0] idx;
    idx = (a - RV) >> 2;
    if (a >= RV && idx < MW) return prog[idx];
    return 32'd0;
  endfunction

  always @(posedge clk) begin
    mem_rvalid <= mem_req & ~rst;
    mem_rdata  <= rd(mem_addr);
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd_instr(input int cls);
    logic [31:0] w;
    w = $urandom;
    case (cls)
      0: w[31:30] = 2'($urandom % 3);
      1: begin w[31:30] = 2'b11; w[15] = 1'b0; end
      2: begin w[31:30] = 2'b11; w[15] = 1'b1; w[9] = 1'b0; end
      default: begin w[31:30] = 2'b11; w[15] = 1'b1; w[9] = 1'b1; end
    endcase
    return w;
  endfunction

  task automatic check_bundle(input logic [31:0] epc);
    logic [31:0] w, l, e1, e2;
    logic three, lng;
    w = rd(epc);
    l = rd(epc + 4);
    three = (w[31:30] == 2'b11);
    lng = three & w[15] & w[9];
    chk("R7 pc", dec_pc, epc);
    chk("R2 three_op", {31'd0, dec_three_op}, {31'd0, three});
    chk("R2 other", {31'd0, dec_other}, {31'd0, ~three});
    chk("R6 long flag", {31'd0, dec_long}, {31'd0, lng});
    if (three) begin
      e1 = regs[w[14:10]];
      chk("R3 dst", {27'd0, dec_dst}, {27'd0, w[4:0]});
      chk("R3 op1", dec_op1, e1);
      if (!w[15]) begin
        e2 = regs[w[9:5]];
        chk("R4 op2 register", dec_op2, e2);
      end else if (!w[9]) begin
        e2 = {27'd0, w[9:5]};
        chk("R5 op2 short literal", dec_op2, e2);
      end else begin
        e2 = l;
        chk("R6 op2 long literal", dec_op2, e2);
      end
      chk("R8 mem flag", {31'd0, dec_mem}, {31'd0, w[28]});
      if (w[28]) begin
        chk("R8 subop", {20'd0, dec_subop}, {20'd0, w[27:16]});
        chk("R8 ea", dec_ea, e1 + e2);
      end
    end
  endtask

  initial begin
    int idx, cycles;
    logic [31:0] epc, nxt;
    logic prev_acc;
    void'($urandom(32'd20240607));
    for (int i = 0; i < 32; i++) regs[i] = $urandom;
    regs[1] = 32'h0000_1000;
    regs[3] = 32'hFFFF_FFF0;
    for (int i = 0; i < MW; i++) prog[i] = 32'd0;
    prog[0] = 32'hD000_8607; prog[1] = 32'h0000_0400;
    prog[2] = 32'hC000_0FE5;
    prog[3] = 32'hDABC_8DE9;
    prog[4] = 32'hD000_8E0A; prog[5] = 32'h0000_0020;
    prog[6] = 32'h4000_8200;
    prog[7] = 32'h8000_0000;
    prog[8] = 32'hC000_8000;
    idx = 9;
    while (idx < MW - 2) begin
      int cls;
      cls = int'($urandom % 4);
      prog[idx] = rnd_instr(cls);
      idx++;
      if (cls == 3) begin prog[idx] = $urandom; idx++; end
    end

    rst = 1'b1; rf_we = 1'b0; rf_widx = '0; rf_wdata = '0; dec_ready = 1'b0;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      rf_we = 1'b1; rf_widx = 5'(i); rf_wdata = regs[i];
    end
    @(negedge clk);
    rf_we = 1'b0;
    @(negedge clk);
    chk("R1 valid low in reset", {31'd0, dec_valid}, 32'd0);
    rst = 1'b0;
    #1;
    chk("R1 first request", {31'd0, mem_req}, 32'd1);
    chk("R1 first address", mem_addr, RV);

    epc = RV; cycles = 0; prev_acc = 1'b0;
    while (((epc - RV) >> 2) < STOP_IDX && cycles < 100000) begin
      @(negedge clk);
      cycles++;
      dec_ready = 1'b0;
      if (prev_acc) chk("R9 valid drops after accept", {31'd0, dec_valid}, 32'd0);
      prev_acc = 1'b0;
      if (dec_valid) begin
        check_bundle(epc);
        if ($urandom % 3 != 0) begin
          dec_ready = 1'b1;
          nxt = epc + ((rd(epc)[31:30] == 2'b11 && rd(epc)[15] && rd(epc)[9]) ? 32'd8 : 32'd4);
          #1;
          chk("R7 next request", {31'd0, mem_req}, 32'd1);
          chk("R7 next address", mem_addr, nxt);
          epc = nxt;
          prev_acc = 1'b1;
        end
      end
    end
    if (cycles >= 100000) begin
      nchk++; nfail++;
      $display("FAIL R7 watchdog expired actual=%0d expected=<100000", cycles);
    end
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule